// File: doc/BRIEF.md
# Two-Bit Burst Address Counter

This block produces the address for a synchronous burst memory. A base address is captured from either of two independent load strobes. The upper bits of that address are held in a register and passed straight through. The low bits are driven by a small offset counter that steps through a burst of four locations each time the advance input is high.

A mode input selects the order in which the four locations are visited. With linear order, the start offset is incremented modulo four. With interleaved order, the start offset is XORed with the step count. Bursting is optional: if a strobe is pulsed on every cycle, a fresh external address appears on every cycle with no extra latency.

The current address and the step count within the burst are both outputs. A parameter can fix the block to one order and remove the mode decode. The width of the offset counter is also a parameter; its default of two bits gives bursts of four.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `addr_out` and `burst_pos` are both zero.
- R2: A clock edge with `strobe_a` high makes `addr_out` equal to the `addr_in` value sampled at that edge, and `burst_pos` becomes 0.
- R3: A clock edge with `strobe_b` high has the same effect as R2; the two strobes are interchangeable.
- R4: A clock edge with `advance` high and neither strobe high increments `burst_pos` by one, modulo 4. After value 3 it returns to 0.
- R5: While `linear_order` is 1, the two low bits of `addr_out` equal (start + `burst_pos`) mod 4. Here start is the low two bits of the last loaded address.
- R6: While `linear_order` is 0, the two low bits of `addr_out` equal start XOR `burst_pos`. This is the interleaved order, and it is the order used when the pin is tied low.
- R7: A clock edge with both strobes low and `advance` low leaves `addr_out` and `burst_pos` unchanged.
- R8: Stepping never carries into the upper bits. Between loads, `addr_out[ADDR_W-1:2]` stays equal to the upper bits of the loaded address, including when a burst wraps past the fourth location.
- R9: When a strobe and `advance` are high at the same edge, the load wins: `burst_pos` becomes 0 and `addr_out` takes the new address.
- R10: If a strobe is high on consecutive edges, each edge presents its own `addr_in` on the next cycle with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | External address captured on a load |
| strobe_a | input | 1 | First load strobe, active high |
| strobe_b | input | 1 | Second load strobe, active high |
| advance | input | 1 | Steps the burst offset when no strobe is active |
| linear_order | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_out | output | ADDR_W | Current address: registered upper bits plus the sequenced low bits |
| burst_pos | output | CNT_W | Step count within the current burst |

## Verification
The bench runs five kinds of pattern:
- Bursts started from start offsets 1 and 3 under each order. Offset 1 separates linear order from interleaved order at the second step (2 versus 0). Offset 3 shows the wrap, where a carry into the upper bits would appear.
- Advance pulses broken up by idle cycles. These show that idle cycles hold the count rather than stepping it.
- Strobes that coincide with advance. These show that the load takes priority.
- Back-to-back loads that alternate between the two strobes, with unrelated upper bits. These confirm that every cycle can take a new address and that both strobes are equal.
- A mode flip in the middle of a burst. This shows that the order applies to the stored offset and the step count, not to a stored address.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Variant of the order logic that is built into the block
   typedef enum logic [1:0] {
      ORD_PIN        = 2'd0,  // order chosen at run time by the mode input
      ORD_LINEAR     = 2'd1,  // linear order only
      ORD_INTERLEAVE = 2'd2   // XOR order only
   } order_sel_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (load)
         base_q <= addr_in;
   end

endmodule

// File: rtl/burst_step_count.sv
module burst_step_count #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   output logic [CNT_W-1:0] pos_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // A load restarts the count; otherwise advance steps it and it wraps naturally
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (load)
         pos_q <= '0;
      else if (advance)
         pos_q <= pos_q + ONE;
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int         CNT_W = 2,
   parameter order_sel_e ORDER = ORD_PIN
) (
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] pos,
   input  logic             linear_sel,
   output logic [CNT_W-1:0] low_out
);

   logic [CNT_W-1:0] lin_val;
   logic [CNT_W-1:0] xor_val;

   assign lin_val = start + pos;
   assign xor_val = start ^ pos;

   generate
      if (ORDER == ORD_PIN) begin : g_pin
         assign low_out = linear_sel ? lin_val : xor_val;
      end else if (ORDER == ORD_LINEAR) begin : g_lin
         logic unused_sel;
         assign unused_sel = linear_sel ^ (^xor_val);
         assign low_out    = lin_val;
      end else begin : g_xor
         logic unused_sel;
         assign unused_sel = linear_sel ^ (^lin_val);
         assign low_out    = xor_val;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int         ADDR_W = 20,
   parameter int         CNT_W  = 2,
   parameter order_sel_e ORDER  = ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              strobe_a,
   input  logic              strobe_b,
   input  logic              advance,
   input  logic              linear_order,
   output logic [ADDR_W-1:0] addr_out,
   output logic [CNT_W-1:0]  burst_pos
);

   localparam int UP_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("burst_addr_gen: CNT_W must be at least 1");
      end
      if (UP_W < 1) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed CNT_W");
      end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  pos_q;
   logic [CNT_W-1:0]  low_bits;

   assign load = strobe_a | strobe_b;

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_in (addr_in),
      .base_q  (base_q)
   );

   burst_step_count #(.CNT_W(CNT_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (advance),
      .pos_q   (pos_q)
   );

   burst_order_map #(.CNT_W(CNT_W), .ORDER(ORDER)) u_map (
      .start      (base_q[CNT_W-1:0]),
      .pos        (pos_q),
      .linear_sel (linear_order),
      .low_out    (low_bits)
   );

   assign addr_out  = {base_q[ADDR_W-1:CNT_W], low_bits};
   assign burst_pos = pos_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic              strobe_a,
   input logic              strobe_b,
   input logic              advance,
   input logic              linear_order,
   input logic [ADDR_W-1:0] addr_out,
   input logic [CNT_W-1:0]  burst_pos
);

   logic             ld;
   logic [CNT_W-1:0] shadow_start;

   assign ld = strobe_a | strobe_b;

   // Independent record of the start offset, taken from the inputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_start <= '0;
      else if (ld)
         shadow_start <= addr_in[CNT_W-1:0];
   end

   // R2
   strobe_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_a |=> (addr_out == $past(addr_in)) && (burst_pos == '0));

   // R3
   strobe_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_b |=> (addr_out == $past(addr_in)) && (burst_pos == '0));

   // R4
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !ld) |=> burst_pos == CNT_W'($past(burst_pos) + 1'b1));

   // R5
   linear_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      linear_order |-> addr_out[CNT_W-1:0] == CNT_W'(shadow_start + burst_pos));

   // R6
   xor_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !linear_order |-> addr_out[CNT_W-1:0] == (shadow_start ^ burst_pos));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !advance) |=> $stable(burst_pos) &&
         ((linear_order != $past(linear_order)) || $stable(addr_out)));

   // R8
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(addr_out[ADDR_W-1:CNT_W]));

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && advance) |=> burst_pos == '0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_in      (addr_in),
   .strobe_a     (strobe_a),
   .strobe_b     (strobe_b),
   .advance      (advance),
   .linear_order (linear_order),
   .addr_out     (addr_out),
   .burst_pos    (burst_pos)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

   localparam int AW = 12;
   localparam int CW = 2;
   localparam int BL = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          strobe_a = 1'b0;
   logic          strobe_b = 1'b0;
   logic          advance = 1'b0;
   logic          linear_order = 1'b1;
   logic [AW-1:0] addr_out;
   logic [CW-1:0] burst_pos;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state
   int    m_start = 0;
   int    m_pos = 0;
   string m_cause = "R1";
   bit    m_prev_load = 1'b0;

   always #5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_in      (addr_in),
      .strobe_a     (strobe_a),
      .strobe_b     (strobe_b),
      .advance      (advance),
      .linear_order (linear_order),
      .addr_out     (addr_out),
      .burst_pos    (burst_pos)
   );

   // Behavioural model, updated on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_start = 0; m_pos = 0; m_cause = "R1"; m_prev_load = 1'b0;
      end else if (strobe_a || strobe_b) begin
         m_start = int'(addr_in);
         m_pos = 0;
         if (advance)          m_cause = "R9";
         else if (m_prev_load) m_cause = "R10";
         else if (strobe_a)    m_cause = "R2";
         else                  m_cause = "R3";
         m_prev_load = 1'b1;
      end else if (advance) begin
         m_pos = (m_pos + 1) % BL;
         m_cause = (m_pos == 0) ? "R8" : "R4";
         m_prev_load = 1'b0;
      end else begin
         m_cause = "R7";
         m_prev_load = 1'b0;
      end
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      int lo, exp_addr;
      string otag;
      if (!done) begin
         lo = linear_order ? ((m_start % BL) + m_pos) % BL : ((m_start % BL) ^ m_pos);
         exp_addr = ((m_start / BL) * BL) + lo;
         otag = linear_order ? "R5" : "R6";
         checks++;
         if (int'(addr_out) != exp_addr || int'(burst_pos) != m_pos) begin
            errors++;
            $display("FAIL %s %s R8 t=%0t addr_out=%h exp=%h burst_pos=%0d exp=%0d",
                     m_cause, otag, $time, addr_out, exp_addr, burst_pos, m_pos);
         end
      end
   end

   task automatic cyc(input bit sa, input bit sb, input bit adv, input bit lin,
                      input logic [AW-1:0] a);
      @(negedge clk);
      #1;
      strobe_a = sa; strobe_b = sb; advance = adv; linear_order = lin; addr_in = a;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state observed over several cycles
      repeat (3) cyc(0, 0, 0, 1, 12'hFFF);
      @(negedge clk); #1; rst_n = 1'b1;
      // R2 linear burst from offset 1, full wrap (R4, R5, R8)
      cyc(1, 0, 0, 1, 12'h125);
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 12'h000);
      // R7 hold with idle cycles interleaved
      cyc(0, 0, 0, 1, 12'hABC);
      cyc(0, 0, 1, 1, 12'h000);
      cyc(0, 0, 0, 1, 12'h0F0);
      cyc(0, 0, 0, 1, 12'h0F0);
      // R3 interleaved burst from offset 1 (R6)
      cyc(0, 1, 0, 0, 12'h7A1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 12'h000);
      // R9 load coincides with advance
      cyc(1, 0, 1, 0, 12'h3FF);
      cyc(0, 0, 1, 0, 12'h000);
      cyc(0, 1, 1, 1, 12'h802);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 12'h000);
      // R10 back-to-back loads alternating strobes
      cyc(1, 0, 0, 1, 12'h111);
      cyc(0, 1, 0, 0, 12'hEEE);
      cyc(1, 0, 0, 1, 12'h5A7);
      cyc(0, 1, 0, 0, 12'hA5B);
      cyc(1, 1, 0, 1, 12'h3C6);
      // offset 3 interleaved wrap (R6, R8), then mode flip mid burst
      cyc(0, 1, 0, 0, 12'hFFF);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 12'h000);
      cyc(0, 0, 1, 1, 12'h000);
      cyc(0, 0, 0, 0, 12'h000);
      cyc(0, 0, 0, 1, 12'h000);
      cyc(0, 0, 0, 1, 12'h000);
      @(negedge clk); #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule